// File: doc/BRIEF.md
# Stack Frame Push/Pop Micro-Op Sequencer

This block takes one 16-bit compressed stack-frame instruction (a push, or one of three pop forms) and expands it into a stream of simple micro-ops, one per handshake. The instruction names a contiguous group of callee-saved registers, starting at the return-address register. It also gives an optional extra stack allocation. From these the sequencer builds one memory micro-op per register, then a stack-pointer adjustment. For the pop forms that return, it adds an optional clear of a0 and a jump through the return-address register.

Each micro-op carries a kind, an architectural register index and a signed byte offset from the stack pointer as it stood before the instruction. The register file, the load/store unit and the adder that applies the adjustment are outside the block. The pipeline drives `start` with the instruction, the data-width select and the reduced-register-profile flag. It then drains micro-ops with `uop_ready` until `done` pulses.

Top module: `stk_seq`

## Requirements
- R1: Bits [1:0] of the instruction must be 2'b10. Bits [15:8] choose the form: 8'hB8 is push, 8'hBA is pop, 8'hBE is pop-and-return, and 8'hBC is pop-and-return with a0 cleared. Any other value is illegal.
- R2: The register-list field is bits [7:4]. A value below 4 is illegal. When `embedded` is high, a value above 6 is also illegal. An illegal start raises `illegal` for exactly one cycle (the cycle after `start`), emits no micro-op and leaves `busy` low.
- R3: Register-list value L with 4<=L<=14 names L-3 registers, and L=15 names 13. They are taken in the order x1, x8, x9, x18, x19, …, x27, and memory micro-ops appear in that order.
- R4: Let B be 4 bytes when `xlen64` is 0 and 8 bytes when it is 1. The k-th register (k from 1) has offset -k*B for push and F-k*B for the pop forms, where F is the frame size.
- R5: With `xlen64`=0, the base frame is 16 bytes for L=4..7, 32 for 8..11, 48 for 12..14 and 64 for 15.
- R6: With `xlen64`=1, the base frame is 16 for L=4..5, 32 for 6..7, 48 for 8..9, 64 for 10..11, 80 for 12..13, 96 for 14 and 112 for 15. F is the base frame plus 16 times bits [3:2].
- R7: Kind codes are store=0, load=1, sp-adjust=2, clear=3 and return=4. After the memory micro-ops, one sp-adjust follows, with register 2 and offset -F for push or +F for the pop forms. The clear variant then emits clear (register 10, offset 0). Both return variants end with return (register 1, offset 0).
- R8: A micro-op advances only on a cycle where `uop_valid` and `uop_ready` are both high. While `uop_ready` is low, kind, register and offset hold steady.
- R9: `start` is ignored while `busy` is high. `done` pulses for one cycle, in the cycle after the last micro-op is accepted, and `busy` is low in that cycle.
- R10: After reset, `busy`, `done`, `illegal` and `uop_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin expanding `insn` (accepted only when idle) |
| insn | input | 16 | Compressed push/pop instruction |
| xlen64 | input | 1 | 1 selects 8-byte registers, 0 selects 4-byte |
| embedded | input | 1 | Reduced register profile: limits the register list |
| uop_ready | input | 1 | Consumer accepts the current micro-op |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse after the last micro-op |
| illegal | output | 1 | One-cycle pulse for a rejected instruction |
| uop_valid | output | 1 | A micro-op is presented |
| uop_kind | output | 3 | Micro-op kind code (R7) |
| uop_reg | output | 5 | Architectural register index |
| uop_offset | output | OFFW | Signed byte offset, or the signed stack-pointer adjustment |

## Verification
The hardest case to reach is the largest frame with a stalled consumer and a competing start. This needs the full 13-register list, the maximum extra allocation at 8-byte width, the consumer dropping ready part-way through the stream, and a second `start` arriving mid-sequence. One directed scenario does all of these at once: it withholds ready every third cycle and drives `start` with a different instruction while busy. It then compares the whole recorded stream against the expected one built from the frame tables.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

   typedef enum logic [1:0] {
      FORM_PUSH    = 2'd0,
      FORM_POP     = 2'd1,
      FORM_POPRET  = 2'd2,
      FORM_POPRETZ = 2'd3
   } form_e;

   typedef enum logic [2:0] {
      UOP_STORE = 3'd0,
      UOP_LOAD  = 3'd1,
      UOP_SPADJ = 3'd2,
      UOP_CLEAR = 3'd3,
      UOP_RET   = 3'd4
   } uop_e;

   localparam int FRAME_W = 8;   // widest frame is 112 + 48 = 160 bytes
   localparam int IDX_W   = 4;   // up to 13 + 3 micro-ops
   localparam int MAX_REGS = 13;

   // architectural index of the k-th saved slot (0 = return address)
   function automatic logic [4:0] slot_reg(input logic [IDX_W-1:0] k);
      logic [4:0] r;
      if (k == '0)           r = 5'd1;
      else if (k < IDX_W'(3)) r = 5'(k) + 5'd7;
      else                    r = 5'(k) + 5'd15;
      return r;
   endfunction

endpackage

// File: rtl/stk_seq_decode.sv
module stk_seq_decode
   import stk_seq_pkg::*;
(
   input  logic [15:0]        insn,
   input  logic               xlen64,
   input  logic               embedded,
   output logic               legal,
   output form_e              form,
   output logic [IDX_W-1:0]   nregs,
   output logic [FRAME_W-1:0] frame
);

   logic [3:0] rlist;
   logic [1:0] extra;
   logic       op_ok;
   logic [7:0] span;
   logic [7:0] base;

   assign rlist = insn[7:4];
   assign extra = insn[3:2];

   always_comb begin
      op_ok = (insn[1:0] == 2'b10);
      form  = FORM_PUSH;
      unique case (insn[15:8])
         8'hB8:   form = FORM_PUSH;
         8'hBA:   form = FORM_POP;
         8'hBE:   form = FORM_POPRET;
         8'hBC:   form = FORM_POPRETZ;
         default: op_ok = 1'b0;
      endcase
   end

   assign legal = op_ok && (rlist >= 4'd4) && !(embedded && (rlist > 4'd6));

   // register count: list value minus three, last code jumps by two
   assign nregs = (rlist == 4'd15) ? IDX_W'(MAX_REGS) : IDX_W'(rlist - 4'd3);

   // bytes occupied by the registers, rounded up to 16-byte alignment
   assign span  = xlen64 ? {1'b0, nregs, 3'b000} : {2'b00, nregs, 2'b00};
   assign base  = (span + 8'd15) & 8'hF0;
   assign frame = FRAME_W'(base) + {2'b00, extra, 4'b0000};

   always_comb begin
      if (legal) begin
         assert (nregs >= 1 && nregs <= MAX_REGS)
            else $error("p_count_range_r3: register count out of range");
      end
   end

endmodule

// File: rtl/stk_seq_step.sv
module stk_seq_step
   import stk_seq_pkg::*;
#(
   parameter int OFFW = 9,
   parameter int REGW = 5
)(
   input  logic [IDX_W-1:0]   idx,
   input  logic [IDX_W-1:0]   nregs,
   input  form_e              form,
   input  logic [FRAME_W-1:0] frame,
   input  logic               xlen64,
   output uop_e               kind,
   output logic [REGW-1:0]    rnum,
   output logic [OFFW-1:0]    offs
);

   localparam int SLOT_W = IDX_W + 4;

   logic [SLOT_W-1:0]        slot_bytes;
   logic signed [OFFW-1:0]   mem_neg;
   logic signed [OFFW-1:0]   frm;
   logic                     is_push;

   assign is_push    = (form == FORM_PUSH);
   assign slot_bytes = xlen64 ? SLOT_W'({idx + IDX_W'(1), 3'b000})
                              : SLOT_W'({idx + IDX_W'(1), 2'b00});
   assign mem_neg    = -$signed(OFFW'(slot_bytes));
   assign frm        = $signed(OFFW'(frame));

   always_comb begin
      kind = UOP_RET;
      rnum = REGW'(1);
      offs = '0;
      if (idx < nregs) begin
         kind = is_push ? UOP_STORE : UOP_LOAD;
         rnum = REGW'(slot_reg(idx));
         offs = is_push ? mem_neg : (frm + mem_neg);
      end else if (idx == nregs) begin
         kind = UOP_SPADJ;
         rnum = REGW'(2);
         offs = is_push ? -frm : frm;
      end else if ((idx == nregs + IDX_W'(1)) && (form == FORM_POPRETZ)) begin
         kind = UOP_CLEAR;
         rnum = REGW'(10);
      end
   end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
   import stk_seq_pkg::*;
#(
   parameter int OFFW = 9,
   parameter int REGW = 5
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [15:0]     insn,
   input  logic            xlen64,
   input  logic            embedded,
   input  logic            uop_ready,
   output logic            busy,
   output logic            done,
   output logic            illegal,
   output logic            uop_valid,
   output logic [2:0]      uop_kind,
   output logic [REGW-1:0] uop_reg,
   output logic [OFFW-1:0] uop_offset
);

   if (OFFW < FRAME_W + 1) begin : g_offw_check
      $error("stk_seq: OFFW too narrow for a signed 160-byte frame");
   end
   if (REGW < 5) begin : g_regw_check
      $error("stk_seq: REGW must address 32 registers");
   end

   logic               dec_legal;
   form_e              dec_form;
   logic [IDX_W-1:0]   dec_nregs;
   logic [FRAME_W-1:0] dec_frame;

   stk_seq_decode u_dec (
      .insn     (insn),
      .xlen64   (xlen64),
      .embedded (embedded),
      .legal    (dec_legal),
      .form     (dec_form),
      .nregs    (dec_nregs),
      .frame    (dec_frame)
   );

   logic               busy_q, done_q, ill_q, x64_q;
   form_e              form_q;
   logic [IDX_W-1:0]   nregs_q, idx_q;
   logic [FRAME_W-1:0] frame_q;
   logic [IDX_W-1:0]   last_idx;
   logic               accept, take, is_last;

   assign take    = start && !busy_q;
   assign accept  = busy_q && uop_ready;
   assign last_idx = nregs_q
                   + ((form_q == FORM_POPRET || form_q == FORM_POPRETZ) ? IDX_W'(1) : '0)
                   + ((form_q == FORM_POPRETZ) ? IDX_W'(1) : '0);
   assign is_last = (idx_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         ill_q   <= 1'b0;
         x64_q   <= 1'b0;
         form_q  <= FORM_PUSH;
         nregs_q <= '0;
         frame_q <= '0;
         idx_q   <= '0;
      end else begin
         done_q <= accept && is_last;
         ill_q  <= take && !dec_legal;
         if (take && dec_legal) begin
            busy_q  <= 1'b1;
            x64_q   <= xlen64;
            form_q  <= dec_form;
            nregs_q <= dec_nregs;
            frame_q <= dec_frame;
            idx_q   <= '0;
         end else if (accept) begin
            if (is_last) busy_q <= 1'b0;
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   uop_e step_kind;

   stk_seq_step #(.OFFW(OFFW), .REGW(REGW)) u_step (
      .idx    (idx_q),
      .nregs  (nregs_q),
      .form   (form_q),
      .frame  (frame_q),
      .xlen64 (x64_q),
      .kind   (step_kind),
      .rnum   (uop_reg),
      .offs   (uop_offset)
   );

   assign uop_kind  = step_kind;
   assign uop_valid = busy_q;
   assign busy      = busy_q;
   assign done      = done_q;
   assign illegal   = ill_q;

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid && !uop_ready |=> uop_valid && $stable(uop_kind)
                                  && $stable(uop_reg) && $stable(uop_offset));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !busy && !uop_valid);

   p_ret_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid && uop_ready && uop_kind == 3'd4 |=> done);

   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !(uop_ready && is_last) |=> busy && $stable(form_q) && $stable(frame_q));

endmodule

// File: tb/stk_seq_tb.sv
module stk_seq_tb;

   localparam int OFFW = 9;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [15:0]     insn = '0;
   logic            xlen64 = 1'b0;
   logic            embedded = 1'b0;
   logic            uop_ready = 1'b0;
   logic            busy, done, illegal, uop_valid;
   logic [2:0]      uop_kind;
   logic [4:0]      uop_reg;
   logic [OFFW-1:0] uop_offset;

   int n_checks = 0;
   int n_errors = 0;

   always #2.5 clk = ~clk;

   stk_seq #(.OFFW(OFFW), .REGW(5)) u_dut (
      .clk, .rst_n, .start, .insn, .xlen64, .embedded, .uop_ready,
      .busy, .done, .illegal, .uop_valid, .uop_kind, .uop_reg, .uop_offset
   );

   int ek[16], er[16], eo[16];
   int en;
   int rk[16], rr[16], ro[16];
   int rn;

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   function automatic int frame_of(input int rl, input int sp, input bit x64);
      int b;
      if (!x64) begin
         if (rl <= 7) b = 16; else if (rl <= 11) b = 32; else if (rl <= 14) b = 48; else b = 64;
      end else begin
         case (rl)
            4, 5:    b = 16;
            6, 7:    b = 32;
            8, 9:    b = 48;
            10, 11:  b = 64;
            12, 13:  b = 80;
            14:      b = 96;
            default: b = 112;
         endcase
      end
      return b + 16 * sp;
   endfunction

   task automatic build(input logic [15:0] ins, input bit x64);
      int regs[13] = '{1, 8, 9, 18, 19, 20, 21, 22, 23, 24, 25, 26, 27};
      int rl = int'(ins[7:4]);
      int f = frame_of(rl, int'(ins[3:2]), x64);
      int cnt = (rl == 15) ? 13 : rl - 3;
      int bsz = x64 ? 8 : 4;
      bit push = (ins[15:8] == 8'hB8);
      en = 0;
      for (int k = 0; k < cnt; k++) begin
         ek[en] = push ? 0 : 1;
         er[en] = regs[k];
         eo[en] = push ? -(k + 1) * bsz : f - (k + 1) * bsz;
         en++;
      end
      ek[en] = 2; er[en] = 2; eo[en] = push ? -f : f; en++;
      if (ins[15:8] == 8'hBC) begin ek[en] = 3; er[en] = 10; eo[en] = 0; en++; end
      if (ins[15:8] == 8'hBC || ins[15:8] == 8'hBE) begin
         ek[en] = 4; er[en] = 1; eo[en] = 0; en++;
      end
   endtask

   // expand one legal instruction and compare the whole stream
   task automatic run_ok(input string req, input logic [15:0] ins, input bit x64,
                         input bit emb, input bit stall, input bit poke);
      int guard = 0;
      bit held = 0;
      int hk = 0, hr = 0, ho = 0;
      build(ins, x64);
      rn = 0;
      @(negedge clk);
      insn = ins; xlen64 = x64; embedded = emb; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(req, "busy after start", int'(busy), 1);
      while (!done && guard < 100) begin
         if (held) begin
            chk("R8", "kind held", int'(uop_kind), hk);
            chk("R8", "reg held", int'(uop_reg), hr);
            chk("R8", "offset held", int'($signed(uop_offset)), ho);
            held = 0;
         end
         uop_ready = !(stall && (guard % 3 == 1));
         if (poke && guard == 2) begin
            start = 1'b1; insn = 16'hBAF2; xlen64 = ~x64;
         end else start = 1'b0;
         if (uop_valid && !uop_ready) begin
            held = 1; hk = int'(uop_kind); hr = int'(uop_reg); ho = int'($signed(uop_offset));
         end
         if (uop_valid && uop_ready && rn < 16) begin
            rk[rn] = int'(uop_kind); rr[rn] = int'(uop_reg); ro[rn] = int'($signed(uop_offset));
            rn++;
         end
         guard++;
         @(negedge clk);
      end
      start = 1'b0; uop_ready = 1'b0;
      chk("R9", "done seen", int'(done), 1);
      chk("R9", "busy low at done", int'(busy), 0);
      chk(req, "micro-op count", rn, en);
      for (int i = 0; i < en && i < rn; i++) begin
         chk(req, $sformatf("kind[%0d]", i), rk[i], ek[i]);
         chk(req, $sformatf("reg[%0d]", i), rr[i], er[i]);
         chk(req, $sformatf("offset[%0d]", i), ro[i], eo[i]);
      end
      @(negedge clk);
      chk("R9", "done one cycle", int'(done), 0);
      chk("R9", "stays idle", int'(uop_valid), 0);
   endtask

   task automatic run_bad(input string req, input logic [15:0] ins, input bit emb);
      @(negedge clk);
      insn = ins; embedded = emb; xlen64 = 1'b0; start = 1'b1; uop_ready = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(req, "illegal pulse", int'(illegal), 1);
      chk(req, "no busy", int'(busy), 0);
      chk(req, "no micro-op", int'(uop_valid), 0);
      @(negedge clk);
      chk(req, "illegal clears", int'(illegal), 0);
      chk(req, "still idle", int'(uop_valid), 0);
      uop_ready = 1'b0; embedded = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10", "busy", int'(busy), 0);
      chk("R10", "done", int'(done), 0);
      chk("R10", "illegal", int'(illegal), 0);
      chk("R10", "valid", int'(uop_valid), 0);
   endtask

   task automatic t_push_small();   run_ok("R4", 16'hB852, 1'b0, 1'b0, 1'b0, 1'b0); endtask
   task automatic t_push_full32();  run_ok("R5", 16'hB8FA, 1'b0, 1'b0, 1'b0, 1'b0); endtask
   task automatic t_push_mid32();   run_ok("R3", 16'hB8B2, 1'b0, 1'b0, 1'b0, 1'b0); endtask
   task automatic t_pop64();        run_ok("R6", 16'hBAE6, 1'b1, 1'b0, 1'b0, 1'b0); endtask
   task automatic t_popret32();     run_ok("R7", 16'hBE42, 1'b0, 1'b0, 1'b0, 1'b0); endtask
   task automatic t_popretz_emb();  run_ok("R2", 16'hBC66, 1'b1, 1'b1, 1'b0, 1'b0); endtask
   task automatic t_stall_poke();   run_ok("R8", 16'hBCFE, 1'b1, 1'b0, 1'b1, 1'b1); endtask
   task automatic t_push_max64();   run_ok("R6", 16'hB8FE, 1'b1, 1'b0, 1'b1, 1'b0); endtask

   task automatic t_illegal();
      run_bad("R2", 16'hB832, 1'b0);   // list value 3
      run_bad("R2", 16'hBA72, 1'b1);   // list 7 with reduced profile
      run_bad("R1", 16'hB952, 1'b0);   // unknown form byte
      run_bad("R1", 16'hB853, 1'b0);   // wrong low bits
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_errors++; n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_push_small();
      t_push_mid32();
      t_push_full32();
      t_pop64();
      t_popret32();
      t_popretz_emb();
      t_illegal();
      t_stall_poke();
      t_push_max64();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule